// File: doc/BRIEF.md
# Received audio sample conditioner

This block sits between an audio receiver's sample recovery and its serial output stage. For each incoming 24-bit sample it does three things in a fixed order. First, it can shorten the word length to the value carried in the channel-status length code. Second, it handles a sample that arrives with a receive error according to a selectable concealment policy. Third, it forces the result to silence when the output mute control is set.

Truncation only matters when the de-emphasis path downstream is active, so the block applies it only when both the truncate control and the de-emphasis-active flag are high. For concealment, the block keeps a register that holds the last good sample. The conditioned sample is registered and appears one clock after its input strobe, together with an output valid.

Top module: `sample_conditioner`

## Requirements
- R1: After reset, `out_valid` is 0, `out_sample` is 0, and the held last-good sample is 0.
- R2: `out_valid` equals the value `in_valid` had one clock earlier. `out_sample` changes only in the cycle after a strobe and otherwise keeps its value.
- R3: When `trunc_en` is 0, or `deemph_on` is 0, the sample passes at its full 24 bits, whatever `aux_len` is.
- R4: When `trunc_en` and `deemph_on` are both 1, the effective word length is 24 minus `aux_len`, with a floor of 8 bits. The sample keeps only that many most significant bits, and the remaining low bits become 0.
- R5: With `err_policy` = 2'b00 and `rx_err` = 1, the output is the last good sample. That value is taken after truncation, and it is 0 if no good sample has arrived since reset.
- R6: With `err_policy` = 2'b01 and `rx_err` = 1, the output is all zeros.
- R7: With `err_policy` = 2'b10 and `rx_err` = 1, the output is the received sample, after any truncation.
- R8: `err_policy` = 2'b11 behaves exactly like 2'b00.
- R9: The held last-good sample is loaded only by strobes with `rx_err` = 0. Errored strobes and idle cycles leave it unchanged.
- R10: When `mute` = 1, the output sample is all zeros whatever the error state, policy or truncation. The held sample still follows R9 while mute is set.
- R11: When `rx_err` = 0, `err_policy` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 24 | Received sample |
| rx_err | input | 1 | Receive error flag for this sample |
| aux_len | input | 4 | Channel-status length code (bits removed) |
| trunc_en | input | 1 | Truncate enable |
| deemph_on | input | 1 | De-emphasis path active |
| err_policy | input | 2 | 00 hold last good, 01 zero, 10 pass, 11 as 00 |
| mute | input | 1 | Force output to zero |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 24 | Conditioned sample |

## Verification
Concealment and truncation can act on the same sample, and mute can override both in that same cycle. The bench provokes this by sending errored strobes while truncation is enabled under every policy. It checks that hold uses the truncated earlier sample, that the pass policy returns the truncated current sample, and that mute still gives zero. Random stimulus that mixes all the controls on back-to-back strobes is judged against a bench model that tracks the held sample on its own.

// File: rtl/sample_cond_pkg.sv
package sample_cond_pkg;

   typedef enum logic [1:0] {
      POL_HOLD     = 2'b00,
      POL_ZERO     = 2'b01,
      POL_PASS     = 2'b10,
      POL_RESERVED = 2'b11
   } conceal_pol_e;

   function automatic logic uses_hold(input conceal_pol_e p);
      return (p == POL_HOLD) || (p == POL_RESERVED);
   endfunction

endpackage

// File: rtl/sample_trunc.sv
module sample_trunc #(
   parameter int SAMPLE_W = 24,
   parameter int CODE_W   = 4,
   parameter int MIN_LEN  = 8
) (
   input  logic [SAMPLE_W-1:0] din,
   input  logic [CODE_W-1:0]   code,
   input  logic                active,
   output logic [SAMPLE_W-1:0] dout
);
   localparam int DROP_W   = $clog2(SAMPLE_W + 1);
   localparam int MAX_DROP = SAMPLE_W - MIN_LEN;

   if (MIN_LEN < 1 || MIN_LEN > SAMPLE_W) begin : g_bad_min
      $error("sample_trunc: MIN_LEN out of range");
   end
   if (CODE_W >= DROP_W + 2) begin : g_bad_code
      $error("sample_trunc: CODE_W too wide for SAMPLE_W");
   end

   logic [DROP_W-1:0]   drop_raw;
   logic [DROP_W-1:0]   drop_lim;
   logic [SAMPLE_W-1:0] keep;

   always_comb begin
      drop_raw = DROP_W'(code);
      if (int'(code) > MAX_DROP) drop_lim = DROP_W'(MAX_DROP);
      else                       drop_lim = drop_raw;
   end

   for (genvar i = 0; i < SAMPLE_W; i++) begin : g_mask
      assign keep[i] = !active || (DROP_W'(i) >= drop_lim);
   end

   assign dout = din & keep;

   // R4: the most significant kept bits always survive
   always_comb begin
      assert (dout[SAMPLE_W-1] == din[SAMPLE_W-1]);
   end
endmodule

// File: rtl/sample_conceal.sv
module sample_conceal
   import sample_cond_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid,
   input  logic                err,
   input  conceal_pol_e        policy,
   input  logic [SAMPLE_W-1:0] din,
   output logic [SAMPLE_W-1:0] dout
);
   logic [SAMPLE_W-1:0] held_q;
   logic                good;

   assign good = valid && !err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held_q <= '0;
      else if (good) held_q <= din;
   end

   always_comb begin
      if (!err)                  dout = din;
      else if (uses_hold(policy)) dout = held_q;
      else if (policy == POL_ZERO) dout = '0;
      else                        dout = din;
   end

   assert_held_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && !err) |=> $stable(held_q));
   assert_held_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !err) |=> held_q == $past(din));
endmodule

// File: rtl/sample_conditioner.sv
module sample_conditioner
   import sample_cond_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int CODE_W   = 4,
   parameter int MIN_LEN  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic                rx_err,
   input  logic [CODE_W-1:0]   aux_len,
   input  logic                trunc_en,
   input  logic                deemph_on,
   input  logic [1:0]          err_policy,
   input  logic                mute,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_sample
);
   logic [SAMPLE_W-1:0] trunc_s;
   logic [SAMPLE_W-1:0] conc_s;
   logic [SAMPLE_W-1:0] final_s;

   sample_trunc #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .MIN_LEN(MIN_LEN)) u_trunc (
      .din    (in_sample),
      .code   (aux_len),
      .active (trunc_en && deemph_on),
      .dout   (trunc_s)
   );

   sample_conceal #(.SAMPLE_W(SAMPLE_W)) u_conceal (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (in_valid),
      .err    (rx_err),
      .policy (conceal_pol_e'(err_policy)),
      .din    (trunc_s),
      .dout   (conc_s)
   );

   assign final_s = mute ? '0 : conc_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sample <= final_s;
      end
   end

   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(out_sample));
   assert_mute_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mute) |=> out_sample == '0);
   assert_zero_policy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rx_err && err_policy == 2'b01) |=> out_sample == '0);
   assert_full_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !rx_err && !mute && !(trunc_en && deemph_on)) |=> out_sample == $past(in_sample));
   assert_lsb_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && trunc_en && deemph_on && aux_len != '0 && !rx_err) |=> out_sample[0] == 1'b0);
endmodule

// File: tb/sample_conditioner_tb.sv
`timescale 1ns/1ps
module sample_conditioner_tb;
   localparam int W = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [W-1:0] in_sample = '0;
   logic        rx_err = 1'b0;
   logic [3:0]  aux_len = '0;
   logic        trunc_en = 1'b0;
   logic        deemph_on = 1'b0;
   logic [1:0]  err_policy = '0;
   logic        mute = 1'b0;
   logic        out_valid;
   logic [W-1:0] out_sample;

   int checks = 0;
   int fails  = 0;
   logic done = 1'b0;
   logic [W-1:0] m_held = '0;
   logic [W-1:0] m_out  = '0;

   always #2.5 clk = ~clk;

   sample_conditioner u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .rx_err(rx_err), .aux_len(aux_len), .trunc_en(trunc_en), .deemph_on(deemph_on),
      .err_policy(err_policy), .mute(mute), .out_valid(out_valid), .out_sample(out_sample)
   );

   function automatic logic [W-1:0] f_trunc(input logic [W-1:0] s, input logic [3:0] c,
                                            input logic t, input logic d);
      int drop;
      if (!(t && d)) return s;
      drop = int'(c);
      if (drop > W - 8) drop = W - 8;
      return s & ~((24'd1 << drop) - 24'd1);
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one strobe at a falling edge, check one clock later
   task automatic strobe(input string req, input logic [W-1:0] s, input logic e,
                         input logic [3:0] c, input logic t, input logic d,
                         input logic [1:0] p, input logic m);
      logic [W-1:0] ts;
      logic [W-1:0] cs;
      in_valid = 1'b1; in_sample = s; rx_err = e; aux_len = c;
      trunc_en = t; deemph_on = d; err_policy = p; mute = m;
      ts = f_trunc(s, c, t, d);
      if (!e)             cs = ts;
      else if (p == 2'b01) cs = '0;
      else if (p == 2'b10) cs = ts;
      else                 cs = m_held;
      if (!e) m_held = ts;
      m_out = m ? '0 : cs;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, out_sample, m_out);
      check({req, " valid"}, {23'd0, out_valid}, 24'd1);
   endtask

   task automatic idle(input string req);
      in_valid = 1'b0;
      in_sample = 24'hA5A5A5;
      @(negedge clk);
      check(req, out_sample, m_out);
      check({req, " valid"}, {23'd0, out_valid}, 24'd0);
   endtask

   initial begin
      #100000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset data", out_sample, 24'd0);
      check("R1 reset valid", {23'd0, out_valid}, 24'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R5: held is zero right after reset
      strobe("R5 hold after reset", 24'h123456, 1'b1, 4'd0, 1'b0, 1'b0, 2'b00, 1'b0);
      // R3: full width with truncate off or de-emphasis off
      strobe("R3 trunc off", 24'hFFFFFF, 1'b0, 4'd8, 1'b0, 1'b1, 2'b00, 1'b0);
      strobe("R3 deemph off", 24'hFFFFFF, 1'b0, 4'd8, 1'b1, 1'b0, 2'b00, 1'b0);
      idle("R2 idle hold");
      // R4: lengths 24, 20, 9
      strobe("R4 code0", 24'hFFFFFF, 1'b0, 4'd0, 1'b1, 1'b1, 2'b00, 1'b0);
      check("R4 code0 literal", out_sample, 24'hFFFFFF);
      strobe("R4 code4", 24'hFFFFFF, 1'b0, 4'd4, 1'b1, 1'b1, 2'b00, 1'b0);
      check("R4 code4 literal", out_sample, 24'hFFFFF0);
      strobe("R4 code15", 24'hFFFFFF, 1'b0, 4'd15, 1'b1, 1'b1, 2'b00, 1'b0);
      check("R4 code15 literal", out_sample, 24'hFF8000);
      // concealment combined with truncation
      strobe("R5 load good", 24'h7ABCDE, 1'b0, 4'd8, 1'b1, 1'b1, 2'b00, 1'b0);
      strobe("R5 hold truncated", 24'h111111, 1'b1, 4'd0, 1'b0, 1'b0, 2'b00, 1'b0);
      check("R5 hold literal", out_sample, 24'h7ABC00);
      strobe("R8 reserved holds", 24'h222222, 1'b1, 4'd0, 1'b0, 1'b0, 2'b11, 1'b0);
      check("R8 literal", out_sample, 24'h7ABC00);
      strobe("R6 zero policy", 24'h333333, 1'b1, 4'd0, 1'b0, 1'b0, 2'b01, 1'b0);
      strobe("R7 pass truncated", 24'h3456FF, 1'b1, 4'd8, 1'b1, 1'b1, 2'b10, 1'b0);
      check("R7 literal", out_sample, 24'h345600);
      // R9: errored strobe under pass did not reload held
      strobe("R9 held unchanged", 24'h444444, 1'b1, 4'd0, 1'b0, 1'b0, 2'b00, 1'b0);
      check("R9 literal", out_sample, 24'h7ABC00);
      // R10: mute wins; held still loads during mute
      strobe("R10 mute good", 24'h5A5A5A, 1'b0, 4'd0, 1'b0, 1'b0, 2'b10, 1'b1);
      strobe("R10 mute err", 24'h6B6B6B, 1'b1, 4'd4, 1'b1, 1'b1, 2'b10, 1'b1);
      strobe("R10 held loaded under mute", 24'h000001, 1'b1, 4'd0, 1'b0, 1'b0, 2'b00, 1'b0);
      check("R10 literal", out_sample, 24'h5A5A5A);
      // R11: policy ignored without error
      strobe("R11 no err pol01", 24'h0F0F0F, 1'b0, 4'd0, 1'b0, 1'b0, 2'b01, 1'b0);
      check("R11 literal", out_sample, 24'h0F0F0F);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 4) == 0) idle("R2 random idle");
         else strobe("R2-mix random", 24'($urandom), ($urandom_range(0, 2) == 0),
                     4'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                     ($urandom_range(0, 7) == 0));
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule